// File: doc/BRIEF.md
# Floating-Point Load Data Formatter

This block is one registered pipeline stage that sits behind the load data return path of a floating-point unit. It takes the raw bytes a memory load has fetched and builds an 82-bit floating-point register value. That value has a 1-bit sign, a 17-bit exponent biased by 65535, and a 64-bit significand whose integer bit is explicit.

Several load variants are handled in the same stage:

- conversion of 4-byte, 8-byte and 10-byte memory formats;
- a raw 8-byte integer placement;
- a 16-byte spill reload that is copied with no conversion;
- speculative loads whose fault has been deferred;
- advanced loads, which either request an entry in an external advanced-load table or, for a page flagged non-speculative, produce a zeroed result.

In the same cycle the stage computes the post-load base register value. It adds either a sign-extended 9-bit immediate or a register operand to the base, and it carries that operand's NaT bit onto the updated base. The access address it reports is always the base from before the update.

Top module: `fpld_format`

## Requirements
- R1: Every output is registered. `out_valid` is high exactly one cycle after `in_valid` and low otherwise, and reset clears every output to zero.
- R2: With form code 0, size code 0 converts bits 31:0 as a single value (bias 127), size code 1 converts bits 63:0 as a double value (bias 1023), and size code 2 converts bits 79:0 as an extended value (bias 16383, explicit integer bit). For normal numbers the exponent is rebiased to 65535. For single and double the hidden one is placed in significand bit 63 and the fraction is placed directly below it.
- R3: Special inputs are mapped as follows, with the sign kept in every case:
  - A zero becomes exponent 0 with significand 0.
  - An all-ones exponent (infinity or NaN) becomes exponent 0x1FFFF, with bit 63 set and the fraction or payload left-aligned below it.
  - A single or double denormal becomes exponent 65535-bias+1, with integer bit 0 and the fraction left-aligned.
- R4: Form code 1 (integer) gives sign 0, exponent 0x1003E and significand equal to bits 63:0 of the load data, unchanged.
- R5: Form code 2 (fill) copies load bits 63:0 to the significand, bits 80:64 to the exponent and bit 81 to the sign. Bits above 81 are ignored.
- R6: Load type code 1 (speculative) with `defer_req` high gives the NaTVal value: sign 0, exponent 0x1FFFE, significand 0. This takes priority over every form. With `defer_req` low, a speculative load behaves like a normal one.
- R7: Load type code 2 (advanced) with `page_nonspec` low raises `adv_tbl_ins` for exactly the one output cycle of that load, and the data is formatted normally. No other load type raises it.
- R8: Load type code 2 (advanced) with `page_nonspec` high never raises `adv_tbl_ins`. It gives sign 0, exponent 0x1003E and significand 0 in integer form, and all 82 bits zero in every other form.
- R9: Update mode code 0 leaves the base unchanged. Code 1 adds `upd_reg`. Code 2 adds `upd_imm` sign-extended from 9 bits. All sums wrap modulo 2^AW.
- R10: `new_base_nat` equals `upd_reg_nat` in update mode 1 and is 0 in every other mode.
- R11: `acc_addr` is the pre-update `base_addr` of the same load, whatever the update mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A load result is presented this cycle |
| ld_data | input | DATA_W (128) | Raw load bytes, little-endian, byte 0 in bits 7:0 |
| ld_size | input | 2 | 0 single, 1 double, 2 extended |
| ld_form | input | 2 | 0 converted, 1 integer, 2 fill |
| ld_kind | input | 2 | 0 normal, 1 speculative, 2 advanced |
| page_nonspec | input | 1 | Accessed page carries the non-speculative attribute |
| defer_req | input | 1 | Speculative fault is to be deferred |
| base_addr | input | AW (64) | Base register value before update |
| upd_mode | input | 2 | 0 none, 1 register, 2 immediate |
| upd_reg | input | AW (64) | Register update operand |
| upd_reg_nat | input | 1 | NaT bit of the register operand |
| upd_imm | input | IMM_W (9) | Signed immediate update operand |
| out_valid | output | 1 | Outputs below belong to a load |
| fr_value | output | 82 | Register value {sign, exponent, significand} |
| acc_addr | output | AW (64) | Address the load used (old base) |
| new_base | output | AW (64) | Updated base register value |
| new_base_nat | output | 1 | NaT bit for the updated base |
| adv_tbl_ins | output | 1 | Insert strobe for the advanced-load table |

## Verification
The assertions compare each registered output with the inputs sampled on the previous edge. They therefore assume that the control codes stay within the listed values and that the inputs are stable around the sampling edge. Codes of 3 are reserved. The stimulus drives only listed codes and changes every input on the falling edge, one load per task, with idle cycles between some of the loads so that the drop of `out_valid` and `adv_tbl_ins` is also observed.

// File: rtl/fpld_pkg.sv
package fpld_pkg;
  localparam int EXP_W    = 17;
  localparam int SIG_W    = 64;
  localparam int FR_W     = 1 + EXP_W + SIG_W;
  localparam int REG_BIAS = 65535;

  localparam logic [EXP_W-1:0] EXP_INT63  = 17'h1003E;
  localparam logic [EXP_W-1:0] EXP_NATVAL = 17'h1FFFE;
  localparam logic [EXP_W-1:0] EXP_INFNAN = 17'h1FFFF;

  localparam logic [1:0] SZ_SGL = 2'd0;
  localparam logic [1:0] SZ_DBL = 2'd1;
  localparam logic [1:0] FM_CVT = 2'd0;
  localparam logic [1:0] FM_INT = 2'd1;
  localparam logic [1:0] FM_FILL = 2'd2;
  localparam logic [1:0] KD_SPEC = 2'd1;
  localparam logic [1:0] KD_ADV  = 2'd2;
  localparam logic [1:0] UP_NONE = 2'd0;
  localparam logic [1:0] UP_REG  = 2'd1;
  localparam logic [1:0] UP_IMM  = 2'd2;

  typedef struct packed {
    logic              sign;
    logic [EXP_W-1:0]  exp;
    logic [SIG_W-1:0]  sig;
  } freg_t;

  function automatic freg_t natval_word();
    freg_t r;
    r.sign = 1'b0;
    r.exp  = EXP_NATVAL;
    r.sig  = '0;
    return r;
  endfunction

  function automatic freg_t int_word(input logic [SIG_W-1:0] bits);
    freg_t r;
    r.sign = 1'b0;
    r.exp  = EXP_INT63;
    r.sig  = bits;
    return r;
  endfunction
endpackage

// File: rtl/fpld_ieee_cvt.sv
module fpld_ieee_cvt
  import fpld_pkg::*;
#(
  parameter int EW   = 8,
  parameter int MW   = 23,
  parameter bit EXPL = 1'b0
) (
  input  logic [EW+MW:0] raw,
  output freg_t          fr
);
  localparam int SRC_BIAS = (1 << (EW - 1)) - 1;
  localparam logic [EXP_W-1:0] REBIAS  = EXP_W'(REG_BIAS - SRC_BIAS);
  localparam logic [EXP_W-1:0] SUB_EXP = EXP_W'(REG_BIAS - SRC_BIAS + 1);

  logic          sgn;
  logic [EW-1:0] e;
  logic [MW-1:0] m;
  logic          e_zero, e_max, m_zero;
  logic [SIG_W-1:0] sig_norm, sig_sub;

  assign sgn    = raw[EW+MW];
  assign e      = raw[EW+MW-1:MW];
  assign m      = raw[MW-1:0];
  assign e_zero = (e == '0);
  assign e_max  = (e == '1);
  assign m_zero = (m == '0);

  generate
    if (EXPL) begin : g_explicit
      assign sig_norm = SIG_W'(m);
      assign sig_sub  = SIG_W'(m);
    end else begin : g_hidden
      assign sig_norm = {1'b1, m, {(SIG_W-1-MW){1'b0}}};
      assign sig_sub  = {1'b0, m, {(SIG_W-1-MW){1'b0}}};
    end
  endgenerate

  always_comb begin
    fr.sign = sgn;
    if (e_zero && m_zero) begin
      fr.exp = '0;
      fr.sig = '0;
    end else if (e_zero) begin
      fr.exp = SUB_EXP;
      fr.sig = sig_sub;
    end else if (e_max) begin
      fr.exp = EXP_INFNAN;
      fr.sig = sig_norm;
    end else begin
      fr.exp = EXP_W'(e) + REBIAS;
      fr.sig = sig_norm;
    end
  end
endmodule

// File: rtl/fpld_unpack.sv
module fpld_unpack
  import fpld_pkg::*;
(
  input  logic [79:0] data,
  input  logic [1:0]  size,
  output freg_t       fr
);
  freg_t fr_sgl, fr_dbl, fr_ext;

  fpld_ieee_cvt #(.EW(8),  .MW(23), .EXPL(1'b0)) u_sgl (.raw(data[31:0]), .fr(fr_sgl));
  fpld_ieee_cvt #(.EW(11), .MW(52), .EXPL(1'b0)) u_dbl (.raw(data[63:0]), .fr(fr_dbl));
  fpld_ieee_cvt #(.EW(15), .MW(64), .EXPL(1'b1)) u_ext (.raw(data[79:0]), .fr(fr_ext));

  always_comb begin
    case (size)
      SZ_SGL:  fr = fr_sgl;
      SZ_DBL:  fr = fr_dbl;
      default: fr = fr_ext;
    endcase
  end
endmodule

// File: rtl/fpld_base_upd.sv
module fpld_base_upd
  import fpld_pkg::*;
#(
  parameter int AW    = 64,
  parameter int IMM_W = 9
) (
  input  logic [AW-1:0]    base,
  input  logic [1:0]       mode,
  input  logic [AW-1:0]    reg_op,
  input  logic             reg_nat,
  input  logic [IMM_W-1:0] imm,
  output logic [AW-1:0]    sum,
  output logic             nat
);
  logic [AW-1:0] imm_ext;
  logic [AW-1:0] addend;

  assign imm_ext = {{(AW-IMM_W){imm[IMM_W-1]}}, imm};

  always_comb begin
    case (mode)
      UP_REG:  addend = reg_op;
      UP_IMM:  addend = imm_ext;
      default: addend = '0;
    endcase
  end

  assign sum = base + addend;
  assign nat = (mode == UP_REG) && reg_nat;
endmodule

// File: rtl/fpld_format.sv
module fpld_format
  import fpld_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int AW     = 64,
  parameter int IMM_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [1:0]        ld_size,
  input  logic [1:0]        ld_form,
  input  logic [1:0]        ld_kind,
  input  logic              page_nonspec,
  input  logic              defer_req,
  input  logic [AW-1:0]     base_addr,
  input  logic [1:0]        upd_mode,
  input  logic [AW-1:0]     upd_reg,
  input  logic              upd_reg_nat,
  input  logic [IMM_W-1:0]  upd_imm,
  output logic              out_valid,
  output logic [FR_W-1:0]   fr_value,
  output logic [AW-1:0]     acc_addr,
  output logic [AW-1:0]     new_base,
  output logic              new_base_nat,
  output logic              adv_tbl_ins
);
  freg_t         cvt_fr, fill_fr, res_fr;
  logic          sel_natval, sel_advzero, ins_req;
  logic [AW-1:0] upd_sum;
  logic          upd_nat;
  logic          unused_hi;

  assign unused_hi = ^ld_data[DATA_W-1:FR_W];

  fpld_unpack u_unpack (.data(ld_data[79:0]), .size(ld_size), .fr(cvt_fr));

  fpld_base_upd #(.AW(AW), .IMM_W(IMM_W)) u_base (
    .base(base_addr), .mode(upd_mode), .reg_op(upd_reg),
    .reg_nat(upd_reg_nat), .imm(upd_imm), .sum(upd_sum), .nat(upd_nat)
  );

  assign fill_fr     = freg_t'(ld_data[FR_W-1:0]);
  assign sel_natval  = (ld_kind == KD_SPEC) && defer_req;
  assign sel_advzero = (ld_kind == KD_ADV) && page_nonspec;
  assign ins_req     = (ld_kind == KD_ADV) && !page_nonspec;

  always_comb begin
    if (sel_natval)                 res_fr = natval_word();
    else if (sel_advzero)           res_fr = (ld_form == FM_INT) ? int_word('0) : '0;
    else if (ld_form == FM_FILL)    res_fr = fill_fr;
    else if (ld_form == FM_INT)     res_fr = int_word(ld_data[SIG_W-1:0]);
    else                            res_fr = cvt_fr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      fr_value     <= '0;
      acc_addr     <= '0;
      new_base     <= '0;
      new_base_nat <= 1'b0;
      adv_tbl_ins  <= 1'b0;
    end else begin
      out_valid   <= in_valid;
      adv_tbl_ins <= in_valid && ins_req;
      if (in_valid) begin
        fr_value     <= res_fr;
        acc_addr     <= base_addr;
        new_base     <= upd_sum;
        new_base_nat <= upd_nat;
      end
    end
  end

  // R1
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R1
  vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R4
  int_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ld_form == FM_INT && ld_kind == 2'd0)
      |=> (fr_value[SIG_W-1:0] == $past(ld_data[SIG_W-1:0])) && (fr_value[FR_W-2:SIG_W] == 17'h1003E));
  // R6
  natval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ld_kind == KD_SPEC && defer_req) |=> fr_value == {1'b0, 17'h1FFFE, 64'd0});
  // R7
  ins_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ld_kind != KD_ADV) |=> !adv_tbl_ins);
  // R7
  ins_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_tbl_ins |-> out_valid);
  // R8
  nonspec_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ld_kind == KD_ADV && page_nonspec && ld_form != FM_INT)
      |=> (fr_value == '0) && !adv_tbl_ins);
  // R10
  base_nat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && upd_mode != UP_REG) |=> !new_base_nat);
  // R11
  acc_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> acc_addr == $past(base_addr));
endmodule

// File: tb/test_fpld_format.sv
module test_fpld_format;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid;
  logic [127:0] ld_data;
  logic [1:0]   ld_size, ld_form, ld_kind, upd_mode;
  logic         page_nonspec, defer_req, upd_reg_nat;
  logic [63:0]  base_addr, upd_reg;
  logic [8:0]   upd_imm;
  logic         out_valid, new_base_nat, adv_tbl_ins;
  logic [81:0]  fr_value;
  logic [63:0]  acc_addr, new_base;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fpld_format i_fpld_format (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ld_data(ld_data),
    .ld_size(ld_size), .ld_form(ld_form), .ld_kind(ld_kind),
    .page_nonspec(page_nonspec), .defer_req(defer_req), .base_addr(base_addr),
    .upd_mode(upd_mode), .upd_reg(upd_reg), .upd_reg_nat(upd_reg_nat),
    .upd_imm(upd_imm), .out_valid(out_valid), .fr_value(fr_value),
    .acc_addr(acc_addr), .new_base(new_base), .new_base_nat(new_base_nat),
    .adv_tbl_ins(adv_tbl_ins)
  );

  function automatic logic [81:0] frv(input logic s, input logic [16:0] e, input logic [63:0] m);
    return {s, e, m};
  endfunction

  task automatic chk(input string req, input logic [81:0] act, input logic [81:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_in();
    in_valid = 0; ld_data = '0; ld_size = 0; ld_form = 0; ld_kind = 0;
    page_nonspec = 0; defer_req = 0; base_addr = '0; upd_mode = 0;
    upd_reg = '0; upd_reg_nat = 0; upd_imm = '0;
  endtask

  // Drive one load at the falling edge, return at the next falling edge.
  task automatic load(input logic [1:0] sz, input logic [1:0] fm, input logic [1:0] kd,
                      input logic ns, input logic df, input logic [127:0] d);
    clear_in();
    in_valid = 1; ld_size = sz; ld_form = fm; ld_kind = kd;
    page_nonspec = ns; defer_req = df; ld_data = d;
    @(negedge clk);
  endtask

  task automatic idle();
    clear_in();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 reset valid", 82'(out_valid), 82'(0));
    chk("R1 reset value", fr_value, 82'(0));
    chk("R1 reset ins", 82'(adv_tbl_ins), 82'(0));
  endtask

  task automatic t_single();
    load(0, 0, 0, 0, 0, 128'h3F800000);
    chk("R1 valid", 82'(out_valid), 82'(1));
    chk("R2 single 1.0", fr_value, frv(0, 17'h0FFFF, 64'h8000000000000000));
    load(0, 0, 0, 0, 0, 128'hC0200000);
    chk("R2 single -2.5", fr_value, frv(1, 17'h10000, 64'hA000000000000000));
    idle();
    chk("R1 idle valid", 82'(out_valid), 82'(0));
  endtask

  task automatic t_special();
    load(0, 0, 0, 0, 0, 128'h7F800000);
    chk("R3 single inf", fr_value, frv(0, 17'h1FFFF, 64'h8000000000000000));
    load(0, 0, 0, 0, 0, 128'h7FC00001);
    chk("R3 single nan", fr_value, frv(0, 17'h1FFFF, 64'hC000010000000000));
    load(0, 0, 0, 0, 0, 128'h80000000);
    chk("R3 single -0", fr_value, frv(1, 17'h0, 64'h0));
    load(0, 0, 0, 0, 0, 128'h00000001);
    chk("R3 single denormal", fr_value, frv(0, 17'h0FF81, 64'h0000010000000000));
    load(1, 0, 0, 0, 0, 128'h0000000000000000);
    chk("R3 double +0", fr_value, frv(0, 17'h0, 64'h0));
  endtask

  task automatic t_wide();
    load(1, 0, 0, 0, 0, 128'h3FF0000000000000);
    chk("R2 double 1.0", fr_value, frv(0, 17'h0FFFF, 64'h8000000000000000));
    load(1, 0, 0, 0, 0, 128'h4008000000000000);
    chk("R2 double 3.0", fr_value, frv(0, 17'h10000, 64'hC000000000000000));
    load(2, 0, 0, 0, 0, 128'h0000_3FFF_8000000000000000);
    chk("R2 extended 1.0", fr_value, frv(0, 17'h0FFFF, 64'h8000000000000000));
  endtask

  task automatic t_integer();
    load(0, 1, 0, 0, 0, 128'hFFFF_FFFF_0123456789ABCDEF);
    chk("R4 integer", fr_value, frv(0, 17'h1003E, 64'h0123456789ABCDEF));
  endtask

  task automatic t_fill();
    load(0, 2, 0, 0, 0, {64'hFFFFFFFFFFFEABCD, 64'h1122334455667788});
    chk("R5 fill", fr_value, frv(1, 17'h0ABCD, 64'h1122334455667788));
  endtask

  task automatic t_spec();
    load(0, 2, 1, 0, 1, {64'hFFFF, 64'h1234});
    chk("R6 natval", fr_value, frv(0, 17'h1FFFE, 64'h0));
    load(0, 0, 1, 0, 0, 128'h3F800000);
    chk("R6 spec no defer", fr_value, frv(0, 17'h0FFFF, 64'h8000000000000000));
  endtask

  task automatic t_adv();
    load(1, 0, 2, 0, 0, 128'h3FF0000000000000);
    chk("R7 adv insert", 82'(adv_tbl_ins), 82'(1));
    chk("R7 adv data", fr_value, frv(0, 17'h0FFFF, 64'h8000000000000000));
    idle();
    chk("R7 strobe drops", 82'(adv_tbl_ins), 82'(0));
    load(1, 0, 0, 0, 0, 128'h3FF0000000000000);
    chk("R7 normal no insert", 82'(adv_tbl_ins), 82'(0));
    load(0, 1, 2, 1, 0, 128'h0123456789ABCDEF);
    chk("R8 nonspec int", fr_value, frv(0, 17'h1003E, 64'h0));
    chk("R8 nonspec no insert", 82'(adv_tbl_ins), 82'(0));
    load(0, 0, 2, 1, 0, 128'h3F800000);
    chk("R8 nonspec zero", fr_value, 82'(0));
  endtask

  task automatic t_base();
    clear_in(); in_valid = 1; base_addr = 64'h1000; upd_mode = 2; upd_imm = 9'h1FF;
    upd_reg_nat = 1;
    @(negedge clk);
    chk("R9 imm -1", 82'(new_base), 82'(64'h0FFF));
    chk("R10 imm ignores nat", 82'(new_base_nat), 82'(0));
    chk("R11 old base", 82'(acc_addr), 82'(64'h1000));
    clear_in(); in_valid = 1; base_addr = 64'hFFFFFFFFFFFFFFF0; upd_mode = 1;
    upd_reg = 64'h20; upd_reg_nat = 1;
    @(negedge clk);
    chk("R9 reg wrap", 82'(new_base), 82'(64'h10));
    chk("R10 reg nat", 82'(new_base_nat), 82'(1));
    chk("R11 old base reg", 82'(acc_addr), 82'(64'hFFFFFFFFFFFFFFF0));
    clear_in(); in_valid = 1; base_addr = 64'h4000; upd_mode = 0; upd_reg = 64'h99;
    upd_imm = 9'h0FF; upd_reg_nat = 1;
    @(negedge clk);
    chk("R9 no update", 82'(new_base), 82'(64'h4000));
    chk("R10 none nat", 82'(new_base_nat), 82'(0));
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    clear_in();
    @(negedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_single();
    t_special();
    t_wide();
    t_integer();
    t_fill();
    t_spec();
    t_adv();
    t_base();
    idle();
    summary();
  end

  initial begin
    #(20 * 5000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end
endmodule